// File: doc/BRIEF.md
# OTP Word Programming Sequencer

This controller carries out the complete word-by-word programming run for a one-time-programmable memory of 32768 words of 16 bits. A single `start` pulse launches the run. The sequencer first asks for raised supply levels: 6.5 V on the core supply and 13.0 V on the programming supply. It asks for them through two digital request lines. It then steps through every address and fires one program pulse at each one, with no read-back. That blind pass is followed by a verify pass. In the verify pass each word is read back, and while a word still mismatches it gets further pulses, each followed by another read, up to a fixed limit. Once every word verifies, both supplies are requested back to the normal 5.0 V and the whole array is read and compared one final time.

The intended data comes from a source port. That port is indexed by the address the sequencer is presenting, so the source must return the word for `dev_addr` combinationally. The device's read-back arrives on `rd_data`. Analog supply generation sits outside the block. The pulse length is specified in microseconds and is turned into clock cycles from a clock-frequency parameter. The completion flag lasts one cycle. The pass or fail verdict is held, together with the failing address and the phase in which the failure occurred, until the next start.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is high and after it is released, the block is idle: `pgm_strobe`, `oe_en`, `ce_en`, `vcc_hi_req`, `vpp_hi_req`, `busy`, `done`, `pass` and `fail` are all 0.
- R2: After `start`, `vcc_hi_req` and `vpp_hi_req` go to 1 at least one cycle before the first program pulse and stay at 1 for every pulse.
- R3: Every program pulse holds `pgm_strobe` at 1 for exactly PULSE_CYC = CLK_HZ*PULSE_US/1e6 cycles, with a minimum of 1. `dev_addr` is stable during the pulse and `dev_wdata` equals `src_data` for that address.
- R4: The first pass gives each address, in ascending order from 0 to the last, exactly one pulse with no read. `pgm_strobe` and `oe_en` are never 1 in the same cycle.
- R5: Each verify or final read holds `oe_en` at 1 at a fixed address for SETTLE_CYC cycles. Only `rd_data` from the last of those cycles is compared against `src_data`.
- R6: In the verify pass, each mismatch triggers one more pulse followed by another read, up to MAX_RETRY extra pulses per word. The retry count restarts at every address. A word that needs n pulses in total, with n ≤ MAX_RETRY+1, gets exactly n pulses and the run continues.
- R7: If a word still mismatches after MAX_RETRY extra pulses, the run stops. `fail` becomes 1, `fail_addr` holds that address and `fail_final` is 0. Both supply requests drop and no further pulse is issued.
- R8: After the last word verifies, both supply requests drop and every word is read again. The first mismatch ends the run with `fail`=1, `fail_addr` holding that address and `fail_final`=1. If there is no mismatch, `pass`=1.
- R9: `done` is 1 for exactly one cycle per run, in the same cycle that `pass` or `fail` first shows the verdict. `pass` and `fail` are never both 1, and they hold their values until the next accepted `start`. `busy` is 1 from the cycle after `start` until `done`.
- R10: A `start` pulse seen while `busy` is 1 has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run (sampled only when idle) |
| src_data | input | DATA_W | Intended word for the current `dev_addr` |
| rd_data | input | DATA_W | Word read back from the device |
| dev_addr | output | ADDR_W | Address presented to the device and source |
| dev_wdata | output | DATA_W | Data presented to the device during a pulse |
| ce_en | output | 1 | Device enable, active high |
| oe_en | output | 1 | Device read enable, active high |
| pgm_strobe | output | 1 | Program pulse, active high |
| vcc_hi_req | output | 1 | Request raised core supply (1) or normal (0) |
| vpp_hi_req | output | 1 | Request programming supply (1) or normal (0) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion flag |
| pass | output | 1 | Run ended with every word matching |
| fail | output | 1 | Run ended in failure |
| fail_addr | output | ADDR_W | Address of the failing word |
| fail_final | output | 1 | Failure came from the final compare (1) or verify pass (0) |

## Verification
The bench runs an 8-word array model in which every word needs a chosen number of pulses before it reads correctly. The cases include 11 pulses, which is exactly the retry limit and must pass, and 12 pulses, which must fail at the right address after exactly 11 pulses. A sequencer with an off-by-one retry limit would fail the first case or give the second an extra pulse. The model returns garbage until `oe_en` has been held for the full settle time. A design that samples too early would apply pulses the counts do not predict. A word that is corrupted when the supplies drop must be caught by the final compare with `fail_final` set. A design that skipped the final compare would wrongly report pass. Start pulses sent in the middle of a run must leave the pulse counts and the single `done` untouched.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAISE,
        ST_BLIND,
        ST_BGAP,
        ST_VREAD,
        ST_RPULSE,
        ST_LOWER,
        ST_FREAD
    } seq_state_t;

    typedef struct packed {
        logic pgm;
        logic oe;
        logic hv;
    } drive_t;

    function automatic int pulse_cycles(longint hz, longint us);
        longint c;
        c = (hz * us) / 64'd1_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic drive_t state_drive(seq_state_t s);
        drive_t d;
        d.pgm = (s == ST_BLIND) || (s == ST_RPULSE);
        d.oe  = (s == ST_VREAD) || (s == ST_FREAD);
        d.hv  = (s == ST_RAISE) || (s == ST_BLIND) || (s == ST_BGAP) ||
                (s == ST_VREAD) || (s == ST_RPULSE);
        return d;
    endfunction

endpackage

// File: rtl/otp_cycle_timer.sv
module otp_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/otp_step_ctr.sv
module otp_step_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (inc)   q <= q + 1'b1;
    end
endmodule

// File: rtl/otp_word_cmp.sv
module otp_word_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] expect_w,
    input  logic [W-1:0] got_w,
    output logic         match
);
    logic [W-1:0] diff;
    assign diff  = expect_w ^ got_w;
    assign match = (diff == '0);
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 16,
    parameter int CLK_HZ     = 50_000_000,
    parameter int PULSE_US   = 50,
    parameter int MAX_RETRY  = 10,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] src_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              ce_en,
    output logic              oe_en,
    output logic              pgm_strobe,
    output logic              vcc_hi_req,
    output logic              vpp_hi_req,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              fail_final
);
    import otp_seq_pkg::*;

    localparam int PULSE_CYC  = pulse_cycles(CLK_HZ, PULSE_US);
    localparam int SETTLE_EFF = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;
    localparam int TMR_W      = $clog2(imax(PULSE_CYC, SETTLE_EFF) + 1);
    localparam int RTY_W      = $clog2(MAX_RETRY + 2);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam logic [TMR_W-1:0]  T_PULSE   = TMR_W'(PULSE_CYC);
    localparam logic [TMR_W-1:0]  T_SETTLE  = TMR_W'(SETTLE_EFF);
    localparam logic [RTY_W-1:0]  RTY_LIMIT = RTY_W'(MAX_RETRY);

    seq_state_t state, state_nx;
    drive_t     drv;

    logic              tmr_load, tmr_last;
    logic [TMR_W-1:0]  tmr_val;
    logic              addr_clr, addr_inc;
    logic [ADDR_W-1:0] addr;
    logic              rty_clr, rty_inc;
    logic [RTY_W-1:0]  rty;
    logic              match, addr_at_last;
    logic              fin_ok, fin_bad;

    otp_cycle_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
    );

    otp_step_ctr #(.W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .clr(addr_clr), .inc(addr_inc), .q(addr)
    );

    otp_step_ctr #(.W(RTY_W)) u_rty (
        .clk(clk), .rst(rst), .clr(rty_clr), .inc(rty_inc), .q(rty)
    );

    otp_word_cmp #(.W(DATA_W)) u_cmp (
        .expect_w(src_data), .got_w(rd_data), .match(match)
    );

    assign addr_at_last = (addr == LAST_ADDR);

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = T_SETTLE;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        rty_clr  = 1'b0;
        rty_inc  = 1'b0;
        fin_ok   = 1'b0;
        fin_bad  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_RAISE;
                    tmr_load = 1'b1;
                    addr_clr = 1'b1;
                    rty_clr  = 1'b1;
                end
            end
            ST_RAISE: begin
                if (tmr_last) begin
                    state_nx = ST_BLIND;
                    tmr_load = 1'b1;
                    tmr_val  = T_PULSE;
                end
            end
            ST_BLIND: begin
                if (tmr_last) begin
                    if (addr_at_last) begin
                        state_nx = ST_VREAD;
                        addr_clr = 1'b1;
                        tmr_load = 1'b1;
                    end else begin
                        state_nx = ST_BGAP;
                        addr_inc = 1'b1;
                    end
                end
            end
            ST_BGAP: begin
                state_nx = ST_BLIND;
                tmr_load = 1'b1;
                tmr_val  = T_PULSE;
            end
            ST_VREAD: begin
                if (tmr_last) begin
                    if (match) begin
                        rty_clr  = 1'b1;
                        tmr_load = 1'b1;
                        if (addr_at_last) state_nx = ST_LOWER;
                        else              addr_inc = 1'b1;
                    end else if (rty >= RTY_LIMIT) begin
                        fin_bad  = 1'b1;
                        state_nx = ST_IDLE;
                    end else begin
                        rty_inc  = 1'b1;
                        state_nx = ST_RPULSE;
                        tmr_load = 1'b1;
                        tmr_val  = T_PULSE;
                    end
                end
            end
            ST_RPULSE: begin
                if (tmr_last) begin
                    state_nx = ST_VREAD;
                    tmr_load = 1'b1;
                end
            end
            ST_LOWER: begin
                if (tmr_last) begin
                    state_nx = ST_FREAD;
                    addr_clr = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            ST_FREAD: begin
                if (tmr_last) begin
                    if (!match) begin
                        fin_bad  = 1'b1;
                        state_nx = ST_IDLE;
                    end else if (addr_at_last) begin
                        fin_ok   = 1'b1;
                        state_nx = ST_IDLE;
                    end else begin
                        addr_inc = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            done       <= 1'b0;
            pass       <= 1'b0;
            fail       <= 1'b0;
            fail_addr  <= '0;
            fail_final <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= fin_ok | fin_bad;
            if (state == ST_IDLE && start) begin
                pass       <= 1'b0;
                fail       <= 1'b0;
                fail_final <= 1'b0;
            end
            if (fin_ok) pass <= 1'b1;
            if (fin_bad) begin
                fail       <= 1'b1;
                fail_addr  <= addr;
                fail_final <= (state == ST_FREAD);
            end
        end
    end

    assign drv        = state_drive(state);
    assign pgm_strobe = drv.pgm;
    assign oe_en      = drv.oe;
    assign ce_en      = drv.pgm | drv.oe;
    assign vcc_hi_req = drv.hv;
    assign vpp_hi_req = drv.hv;
    assign busy       = (state != ST_IDLE);
    assign dev_addr   = addr;
    assign dev_wdata  = src_data;
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
    parameter int ADDR_W    = 15,
    parameter int PULSE_CYC = 2500
) (
    input logic              clk,
    input logic              rst,
    input logic              pgm_strobe,
    input logic              oe_en,
    input logic              vcc_hi_req,
    input logic              vpp_hi_req,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              done,
    input logic              pass,
    input logic              fail
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst)             run_len <= 0;
        else if (pgm_strobe) run_len <= run_len + 1;
        else                 run_len <= 0;
    end

    // R2
    a_r2_supply_during_pulse: assert property (@(posedge clk) disable iff (rst)
        pgm_strobe |-> (vcc_hi_req && vpp_hi_req));

    // R3
    a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $fell(pgm_strobe) |-> (run_len == PULSE_CYC));

    // R3
    a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
        (pgm_strobe && $past(pgm_strobe)) |-> $stable(dev_addr));

    // R4
    a_r4_no_read_while_pgm: assert property (@(posedge clk) disable iff (rst)
        !(pgm_strobe && oe_en));

    // R9
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    a_r9_verdict_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));
endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .ADDR_W(ADDR_W),
    .PULSE_CYC(otp_seq_pkg::pulse_cycles(CLK_HZ, PULSE_US))
) u_chk (
    .clk(clk), .rst(rst), .pgm_strobe(pgm_strobe), .oe_en(oe_en),
    .vcc_hi_req(vcc_hi_req), .vpp_hi_req(vpp_hi_req), .dev_addr(dev_addr),
    .done(done), .pass(pass), .fail(fail)
);

// File: tb/sim_otp_prog_seq.sv
module sim_otp_prog_seq;
    localparam int AW     = 3;
    localparam int DW     = 16;
    localparam int NW     = 1 << AW;
    localparam int HZ     = 100_000;
    localparam int US     = 50;
    localparam int PCYC   = 5;
    localparam int RETRY  = 10;
    localparam int SETTLE = 3;

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic [DW-1:0] src_data, rd_data;
    logic [AW-1:0] dev_addr, fail_addr;
    logic [DW-1:0] dev_wdata;
    logic ce_en, oe_en, pgm_strobe, vcc_hi_req, vpp_hi_req;
    logic busy, done, pass, fail, fail_final;

    always #10 clk = ~clk;

    otp_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_HZ(HZ), .PULSE_US(US),
                   .MAX_RETRY(RETRY), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst(rst), .start(start), .src_data(src_data), .rd_data(rd_data),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .ce_en(ce_en), .oe_en(oe_en),
        .pgm_strobe(pgm_strobe), .vcc_hi_req(vcc_hi_req), .vpp_hi_req(vpp_hi_req),
        .busy(busy), .done(done), .pass(pass), .fail(fail),
        .fail_addr(fail_addr), .fail_final(fail_final)
    );

    int n_chk = 0;
    int n_fail = 0;
    int seed = 0;

    function automatic logic [DW-1:0] pat(logic [AW-1:0] a, int s);
        return 16'hA500 | DW'((int'(a) * 37 + s) & 8'hFF);
    endfunction

    assign src_data = pat(dev_addr, seed);

    // device model
    int need [NW];
    logic [DW-1:0] mem [NW];
    int pcnt [NW];
    int order [16];
    int n_pulses = 0;
    int stab = 0;
    int plen = 0;
    logic [AW-1:0] prev_a = '0;
    logic [AW-1:0] pulse_a = '0;
    logic prev_oe = 0;
    logic prev_pgm = 0;
    logic prev_vcc = 0;
    bit drift_en = 0;
    int drift_a = 0;
    int hv_lead = 0;
    int first_lead = -1;
    int bad_width = 0;
    int bad_excl = 0;
    int bad_wdata = 0;
    int bad_supply = 0;
    int done_cnt = 0;

    assign rd_data = (oe_en && ce_en && stab >= SETTLE) ? mem[dev_addr] : 16'h0000;

    always @(negedge clk) begin
        if (!rst) begin
            if (pgm_strobe) begin
                pulse_a = dev_addr;
                plen++;
                if (dev_wdata !== pat(dev_addr, seed)) bad_wdata++;
                if (!(vcc_hi_req && vpp_hi_req)) bad_supply++;
                if (first_lead < 0) first_lead = hv_lead;
            end
            if (prev_pgm && !pgm_strobe) begin
                if (plen != PCYC) bad_width++;
                plen = 0;
                pcnt[pulse_a]++;
                if (n_pulses < 16) order[n_pulses] = int'(pulse_a);
                n_pulses++;
                if (pcnt[pulse_a] >= need[pulse_a]) mem[pulse_a] = pat(pulse_a, seed);
            end
            if (pgm_strobe && oe_en) bad_excl++;
            if (vcc_hi_req && vpp_hi_req && !pgm_strobe) hv_lead++;
            if (oe_en && ce_en && prev_oe && dev_addr == prev_a) stab++;
            else if (oe_en && ce_en) stab = 1;
            else stab = 0;
            if (prev_vcc && !vcc_hi_req && drift_en) mem[drift_a] = mem[drift_a] ^ 16'h0001;
            if (done) done_cnt++;
            prev_pgm = pgm_strobe;
            prev_oe  = oe_en;
            prev_a   = dev_addr;
            prev_vcc = vcc_hi_req;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic prep(int s);
        seed = s;
        for (int i = 0; i < NW; i++) begin
            mem[i] = 16'hFFFF;
            pcnt[i] = 0;
            need[i] = 1;
        end
        for (int i = 0; i < 16; i++) order[i] = -1;
        n_pulses = 0; stab = 0; plen = 0; hv_lead = 0; first_lead = -1;
        bad_width = 0; bad_excl = 0; bad_wdata = 0; bad_supply = 0; done_cnt = 0;
        drift_en = 0; prev_pgm = 0; prev_oe = 0; prev_vcc = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    // pokes: number of extra start pulses during the run (R10)
    task automatic run(int fail_at, bit final_fail, int pokes);
        bit got;
        int cyc;
        do_reset();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
        got = 0;
        cyc = 0;
        while (!got && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (pokes > 0 && n_pulses > 0 && (cyc % 7) == 0) begin
                start = 1;
                @(negedge clk);
                start = 0;
                cyc++;
                pokes--;
                if (done) got = 1;
            end
            if (done) got = 1;
        end
        chk(got, "R9", "watchdog: done seen", int'(got), 1);
        if (!got) return;
        chk((fail_at < 0) ? (pass && !fail) : (fail && !pass), "R9",
            "verdict pass", int'(pass), (fail_at < 0) ? 1 : 0);
        if (fail_at >= 0) begin
            chk(fail_addr == AW'(fail_at), final_fail ? "R8" : "R7",
                "fail_addr", int'(fail_addr), fail_at);
            chk(fail_final == final_fail, final_fail ? "R8" : "R7",
                "fail_final", int'(fail_final), int'(final_fail));
        end
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R9", "done cycles", done_cnt, 1);
        chk(!vcc_hi_req && !vpp_hi_req && !busy, "R8", "supplies normal after end",
            int'(vcc_hi_req), 0);
        chk((fail_at < 0) ? pass : fail, "R9", "verdict held", int'(pass), int'(fail_at < 0));
        chk(first_lead >= 1, "R2", "request lead cycles", first_lead, 1);
        chk(bad_supply == 0, "R2", "pulses without supply request", bad_supply, 0);
        chk(bad_width == 0, "R3", "pulses of wrong width", bad_width, 0);
        chk(bad_wdata == 0, "R3", "pulse data mismatches", bad_wdata, 0);
        chk(bad_excl == 0, "R4", "strobe with read enable", bad_excl, 0);
        for (int i = 0; i < NW; i++)
            chk(order[i] == i, "R4", "blind pass order", order[i], i);
        for (int i = 0; i < NW; i++) begin
            int e;
            if (fail_at < 0 || final_fail || i < fail_at) e = need[i];
            else if (i == fail_at) e = RETRY + 1;
            else e = 1;
            // R6 count; an early sample (R5 settle) would add pulses
            chk(pcnt[i] == e, "R6", "pulses at word", pcnt[i], e);
        end
    endtask

    initial begin
        prep(0);
        rst = 1;
        repeat (3) @(negedge clk);
        chk(!pgm_strobe && !oe_en && !ce_en, "R1", "enables in reset", int'(pgm_strobe), 0);
        rst = 0;
        @(negedge clk);
        chk(!vcc_hi_req && !vpp_hi_req, "R1", "supply requests idle", int'(vcc_hi_req), 0);
        chk(!busy && !done && !pass && !fail, "R1", "status idle", int'(busy), 0);

        // single pulse per word
        prep(3);
        run(-1, 0, 0);

        // graded pulse needs, starts poked mid-run (R10)
        prep(11);
        for (int i = 0; i < NW; i++) need[i] = (i % 4) + 1;
        run(-1, 0, 3);

        // boundary: word needs exactly MAX_RETRY+1 pulses
        prep(29);
        need[2] = RETRY + 1;
        run(-1, 0, 0);

        // ends of array at the boundary
        prep(41);
        need[0] = RETRY + 1;
        need[NW-1] = RETRY + 1;
        run(-1, 0, 0);

        // one pulse too many needed -> verify failure (R7)
        prep(53);
        for (int i = 0; i < NW; i++) need[i] = (i < 5) ? 2 : 1;
        need[5] = RETRY + 2;
        run(5, 0, 0);

        // word corrupted when supplies drop -> final compare failure (R8)
        prep(67);
        for (int i = 0; i < NW; i++) need[i] = 2;
        drift_en = 1;
        drift_a = 6;
        run(6, 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule